// File: doc/BRIEF.md
# Cache Tag Lookup Miss Counter

This block watches a stream of memory reference addresses and decides, for each one, whether it would have hit in an 8 KB cache with 32-byte lines. Only the tag store is modelled. There is no data array, no write-back and no backing memory. Loads and stores are not told apart: each one is a plain reference. On a miss the selected way takes the new tag. Two saturating counters keep the running totals of references and misses, and a synchronous clear input zeroes both.

Associativity is chosen at elaboration with `WAYS`, which may be 1, 2 or 4. The total capacity stays the same, so the set count is 256, 128 or 64. The stored tag is the whole address above the 5-bit line offset, index bits included, so each way holds 27 bits per entry. When a set has several ways, it fills an empty way first and otherwise replaces the least recently used way.

Top module: `tagmon_top`

## Requirements
- R1: Address bits [4:0] select a byte inside the 32-byte line and have no effect on the lookup. Two addresses that differ only in those bits are the same line.
- R2: The set is addressed by the address bits just above the offset. Direct-mapped uses bits [12:5] (256 sets), 2-way uses bits [11:5] (128 sets) and 4-way uses bits [10:5] (64 sets).
- R3: The compared tag is address bits [31:5]. A reference hits only when a valid way of its set holds exactly that value.
- R4: On a miss, the way chosen for replacement takes the new tag and becomes valid, so the next reference to the same line hits.
- R5: Reset (`rst` high, synchronous) marks every way invalid, so the first reference to any line afterwards misses. It also holds `res_valid`, `res_hit` and both counters at zero.
- R6: Each cycle with `ref_valid` high is one reference. Back-to-back cycles are allowed. `res_valid` rises exactly one cycle later, and `res_hit` gives that reference's outcome (1 = hit). `res_hit` is 0 whenever `res_valid` is 0.
- R7: `ref_count` increases by one for every reference, hit or miss, in the same cycle that its result appears.
- R8: `miss_count` increases by one for every reference that misses, in the same cycle that its result appears.
- R9: Each counter stops at its all-ones value (width `CNT_W`) and stays there until it is cleared.
- R10: `stat_clr` zeroes both counters on the next edge. It takes priority over a reference in the same cycle: that reference is not counted, but it is still looked up and filled and its result is still reported. The clear leaves the tag store untouched.
- R11: When a set has more than one way, a miss fills the lowest-numbered invalid way. If no way is invalid, it replaces the least recently used way. A hit or a fill makes that way the most recently used.
- R12: For a fixed 8 KB capacity, lines whose addresses are 8192 bytes apart fall in the same set. Direct-mapped mode misses on every alternation between two such lines, while 2-way and 4-way modes hold both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr | input | ADDR_W | Byte address of the reference |
| stat_clr | input | 1 | Synchronous clear of both counters |
| res_valid | output | 1 | Result strobe, one cycle after `ref_valid` |
| res_hit | output | 1 | 1 when the reported reference hit |
| ref_count | output | CNT_W | Saturating count of references |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The assertions assume that `ref_addr` carries a known value in every cycle where `ref_valid` is high. They also assume that reset is held for at least one edge before the first reference. `stat_clr` may arrive in any cycle, including one that carries a reference. The bench drives all inputs on the falling edge and keeps addresses fully defined. It runs one instance of each associativity side by side, gives the 4-way instance a narrow counter so it saturates, and mixes idle gaps with back-to-back references.

// File: rtl/tagmon_pkg.sv
package tagmon_pkg;
   localparam int unsigned DEF_ADDR_W     = 32;
   localparam int unsigned DEF_CAP_BYTES  = 8192;
   localparam int unsigned DEF_LINE_BYTES = 32;
   localparam int unsigned DEF_CNT_W      = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tagmon_way_store.sv
module tagmon_way_store #(
   parameter int unsigned SETS  = 256,
   parameter int unsigned SET_W = 8,
   parameter int unsigned TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_vld,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [TAG_W-1:0] tag_q [SETS];
   logic [SETS-1:0]  vld_q;

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[set_idx] <= wr_tag;
   end

   always_ff @(posedge clk) begin
      if (rst)        vld_q <= '0;
      else if (wr_en) vld_q[set_idx] <= 1'b1;
   end

   assign rd_tag = tag_q[set_idx];
   assign rd_vld = vld_q[set_idx];
endmodule

// File: rtl/tagmon_lru.sv
module tagmon_lru #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned SETS  = 128,
   parameter int unsigned SET_W = 7,
   parameter int unsigned WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_idx,
   input  logic [WAYS-1:0]  vld_vec,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
   logic [WAY_W-1:0] age_q [SETS][WAYS];
   logic [WAY_W-1:0] touch_age;

   assign touch_age = age_q[set_idx][touch_way];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[set_idx][w] <= '0;
            else if (age_q[set_idx][w] < touch_age)
               age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
         end
      end
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!vld_vec[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++)
            if (age_q[set_idx][w] == OLDEST) victim = WAY_W'(w);
      end
   end
endmodule

// File: rtl/tagmon_sat_cnt.sv
module tagmon_sat_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst || clr)            q <= '0;
      else if (inc && q != TOP)  q <= q + 1'b1;
   end
endmodule

// File: rtl/tagmon_top.sv
module tagmon_top
   import tagmon_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned CAP_BYTES  = DEF_CAP_BYTES,
   parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
   parameter int unsigned WAYS       = 1,
   parameter int unsigned CNT_W      = DEF_CNT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ref_valid,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic              stat_clr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [CNT_W-1:0]  ref_count,
   output logic [CNT_W-1:0]  miss_count
);
   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam int unsigned LINES = CAP_BYTES / LINE_BYTES;
   localparam int unsigned SETS  = LINES / WAYS;
   localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int unsigned TAG_W = ADDR_W - OFF_W;
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (!(WAYS == 1 || WAYS == 2 || WAYS == 4)) begin : g_bad_ways
      $error("tagmon_top: WAYS must be 1, 2 or 4");
   end
   if (!is_pow2(LINE_BYTES) || !is_pow2(CAP_BYTES)) begin : g_bad_geom
      $error("tagmon_top: capacity and line size must be powers of two");
   end
   if (SETS < 2 || CAP_BYTES % (LINE_BYTES * WAYS) != 0) begin : g_bad_sets
      $error("tagmon_top: capacity too small for the chosen ways");
   end
   if (ADDR_W <= OFF_W + SET_W) begin : g_bad_addr
      $error("tagmon_top: address too narrow");
   end

   logic [TAG_W-1:0] ref_tag;
   logic [SET_W-1:0] ref_set;
   logic             unused_off;

   assign ref_tag    = ref_addr[ADDR_W-1:OFF_W];
   assign ref_set    = ref_addr[OFF_W +: SET_W];
   assign unused_off = ^ref_addr[OFF_W-1:0];

   logic [TAG_W-1:0] way_tag [WAYS];
   logic [WAYS-1:0]  way_vld;
   logic [WAYS-1:0]  way_hit;
   logic [WAY_W-1:0] victim;
   logic             hit;
   logic             fill;

   assign hit  = |way_hit;
   assign fill = ref_valid && !hit;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      tagmon_way_store #(
         .SETS  (SETS),
         .SET_W (SET_W),
         .TAG_W (TAG_W)
      ) u_store (
         .clk     (clk),
         .rst     (rst),
         .set_idx (ref_set),
         .rd_tag  (way_tag[w]),
         .rd_vld  (way_vld[w]),
         .wr_en   (fill && (victim == WAY_W'(w))),
         .wr_tag  (ref_tag)
      );
      assign way_hit[w] = way_vld[w] && (way_tag[w] == ref_tag);
   end

   if (WAYS > 1) begin : g_assoc
      logic [WAY_W-1:0] hit_way;
      logic [WAY_W-1:0] touch_way;

      always_comb begin
         hit_way = '0;
         for (int w = 0; w < WAYS; w++)
            if (way_hit[w]) hit_way = hit_way | WAY_W'(w);
      end

      assign touch_way = hit ? hit_way : victim;

      tagmon_lru #(
         .WAYS  (WAYS),
         .SETS  (SETS),
         .SET_W (SET_W),
         .WAY_W (WAY_W)
      ) u_lru (
         .clk       (clk),
         .rst       (rst),
         .set_idx   (ref_set),
         .vld_vec   (way_vld),
         .touch_en  (ref_valid),
         .touch_way (touch_way),
         .victim    (victim)
      );
   end else begin : g_direct
      assign victim = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
      end else begin
         res_valid <= ref_valid;
         res_hit   <= ref_valid && hit;
      end
   end

   tagmon_sat_cnt #(.W(CNT_W)) u_ref_cnt (
      .clk (clk),
      .rst (rst),
      .clr (stat_clr),
      .inc (ref_valid),
      .q   (ref_count)
   );

   tagmon_sat_cnt #(.W(CNT_W)) u_miss_cnt (
      .clk (clk),
      .rst (rst),
      .clr (stat_clr),
      .inc (fill),
      .q   (miss_count)
   );
endmodule

// File: rtl/tagmon_chk.sv
module tagmon_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned CNT_W      = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              ref_valid,
   input logic [ADDR_W-1:0] ref_addr,
   input logic              stat_clr,
   input logic              res_valid,
   input logic              res_hit,
   input logic [CNT_W-1:0]  ref_count,
   input logic [CNT_W-1:0]  miss_count
);
   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic                    prev_v;
   logic [ADDR_W-OFF_W-1:0] prev_line;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_v    <= 1'b0;
         prev_line <= '0;
      end else begin
         prev_v    <= ref_valid;
         prev_line <= ref_addr[ADDR_W-1:OFF_W];
      end
   end

   a_r6_result_follows: assert property (@(posedge clk) disable iff (rst)
      ref_valid |=> res_valid);
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !ref_valid |=> !res_valid);
   a_r6_hit_qualified: assert property (@(posedge clk) disable iff (rst)
      !res_valid |-> !res_hit);
   a_r4_repeat_hits: assert property (@(posedge clk) disable iff (rst)
      (ref_valid && prev_v && ref_addr[ADDR_W-1:OFF_W] == prev_line) |=> res_hit);
   a_r7_ref_step: assert property (@(posedge clk) disable iff (rst)
      (!stat_clr && ref_valid && ref_count != TOP) |=> ref_count == $past(ref_count) + 1'b1);
   a_r7_ref_idle: assert property (@(posedge clk) disable iff (rst)
      (!stat_clr && !ref_valid) |=> $stable(ref_count));
   a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
      (!stat_clr && ref_valid && miss_count != TOP)
         |=> miss_count == $past(miss_count) + CNT_W'(res_hit ? 0 : 1));
   a_r8_miss_le_ref: assert property (@(posedge clk) disable iff (rst)
      miss_count <= ref_count);
   a_r9_ref_sat: assert property (@(posedge clk) disable iff (rst)
      (!stat_clr && ref_count == TOP) |=> ref_count == TOP);
   a_r9_miss_sat: assert property (@(posedge clk) disable iff (rst)
      (!stat_clr && miss_count == TOP) |=> miss_count == TOP);
   a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      stat_clr |=> (ref_count == '0 && miss_count == '0));
endmodule

bind tagmon_top tagmon_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .CNT_W      (CNT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ref_valid  (ref_valid),
   .ref_addr   (ref_addr),
   .stat_clr   (stat_clr),
   .res_valid  (res_valid),
   .res_hit    (res_hit),
   .ref_count  (ref_count),
   .miss_count (miss_count)
);

// File: tb/tagmon_top_tb.sv
module tagmon_top_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ref_valid = 1'b0;
   logic [31:0] ref_addr = '0;
   logic        stat_clr = 1'b0;

   always #10 clk = ~clk;

   logic        rv0, rh0, rv1, rh1, rv2, rh2;
   logic [31:0] rc0, mc0, rc1, mc1;
   logic [5:0]  rc2, mc2;

   tagmon_top #(.WAYS(1), .CNT_W(32)) u_dut (
      .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_addr(ref_addr),
      .stat_clr(stat_clr), .res_valid(rv0), .res_hit(rh0),
      .ref_count(rc0), .miss_count(mc0));
   tagmon_top #(.WAYS(2), .CNT_W(32)) u_dut_w2 (
      .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_addr(ref_addr),
      .stat_clr(stat_clr), .res_valid(rv1), .res_hit(rh1),
      .ref_count(rc1), .miss_count(mc1));
   tagmon_top #(.WAYS(4), .CNT_W(6)) u_dut_w4 (
      .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_addr(ref_addr),
      .stat_clr(stat_clr), .res_valid(rv2), .res_hit(rh2),
      .ref_count(rc2), .miss_count(mc2));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string phase = "R5";

   int unsigned m_ways [3] = '{1, 2, 4};
   longint      m_max  [3] = '{64'hFFFF_FFFF, 64'hFFFF_FFFF, 63};
   bit [26:0]   m_tag  [3][4][256];
   bit          m_vld  [3][4][256];
   longint      m_ts   [3][4][256];
   longint      stamp = 0;
   longint      e_ref  [3];
   longint      e_miss [3];
   bit          q_hit  [3][$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint get_ref(input int i);
      return (i == 0) ? longint'(rc0) : (i == 1) ? longint'(rc1) : longint'(rc2);
   endfunction
   function automatic longint get_miss(input int i);
      return (i == 0) ? longint'(mc0) : (i == 1) ? longint'(mc1) : longint'(mc2);
   endfunction

   // reference model: timestamps give true recency, lowest invalid way fills first
   function automatic bit model_ref(input int i, input logic [31:0] a, input bit count);
      int unsigned sets = 256 / m_ways[i];
      int unsigned s    = (a >> 5) % sets;
      bit [26:0]   t    = a[31:5];
      bit          h    = 0;
      int          vic  = -1;
      stamp++;
      for (int w = 0; w < int'(m_ways[i]); w++) begin
         if (m_vld[i][w][s] && m_tag[i][w][s] == t) begin
            h = 1;
            m_ts[i][w][s] = stamp;
         end
      end
      if (!h) begin
         for (int w = 0; w < int'(m_ways[i]); w++)
            if (!m_vld[i][w][s] && vic < 0) vic = w;
         if (vic < 0) begin
            vic = 0;
            for (int w = 1; w < int'(m_ways[i]); w++)
               if (m_ts[i][w][s] < m_ts[i][vic][s]) vic = w;
         end
         m_tag[i][vic][s] = t;
         m_vld[i][vic][s] = 1;
         m_ts[i][vic][s]  = stamp;
      end
      if (count) begin
         if (e_ref[i] < m_max[i]) e_ref[i]++;
         if (!h && e_miss[i] < m_max[i]) e_miss[i]++;
      end
      return h;
   endfunction

   task automatic do_ref(input logic [31:0] a, input bit clr = 0);
      @(negedge clk);
      ref_valid = 1'b1;
      ref_addr  = a;
      stat_clr  = clr;
      for (int i = 0; i < 3; i++) begin
         q_hit[i].push_back(model_ref(i, a, !clr));
         if (clr) begin
            e_ref[i]  = 0;
            e_miss[i] = 0;
         end
      end
   endtask

   task automatic idle(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ref_valid = 1'b0;
         stat_clr  = 1'b0;
      end
   endtask

   task automatic chk_cnt(input string req);
      for (int i = 0; i < 3; i++) begin
         check(get_ref(i) == e_ref[i], req, $sformatf("ref_count w%0d", m_ways[i]),
               get_ref(i), e_ref[i]);
         check(get_miss(i) == e_miss[i], req, $sformatf("miss_count w%0d", m_ways[i]),
               get_miss(i), e_miss[i]);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         for (int i = 0; i < 3; i++) begin
            logic v, h;
            v = (i == 0) ? rv0 : (i == 1) ? rv1 : rv2;
            h = (i == 0) ? rh0 : (i == 1) ? rh1 : rh2;
            if (v) begin
               if (q_hit[i].size() == 0)
                  check(0, "R6", $sformatf("unexpected result w%0d", m_ways[i]), 1, 0);
               else begin
                  bit e;
                  e = q_hit[i].pop_front();
                  check(h == e, phase, $sformatf("res_hit w%0d", m_ways[i]), h, e);
               end
            end else if (h) begin
               check(0, "R6", $sformatf("res_hit without res_valid w%0d", m_ways[i]), 1, 0);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] a;
      for (int i = 0; i < 3; i++) begin
         e_ref[i] = 0; e_miss[i] = 0;
         for (int w = 0; w < 4; w++)
            for (int s = 0; s < 256; s++) begin
               m_vld[i][w][s] = 0; m_tag[i][w][s] = '0; m_ts[i][w][s] = 0;
            end
      end
      repeat (5) @(negedge clk);
      check(rv0 == 0 && rv1 == 0 && rv2 == 0, "R5", "res_valid in reset",
            {rv0, rv1, rv2}, 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk_cnt("R5");

      // R5: first references after reset miss; R4: repeat hits
      phase = "R5";
      do_ref(32'h0000_1040);
      phase = "R4";
      idle();
      do_ref(32'h0000_1040);
      idle(2);
      chk_cnt("R7");

      // R1: byte offset ignored
      phase = "R1";
      do_ref(32'h0000_105F);
      do_ref(32'h0000_1041);
      idle(2);

      // R12: 8 KB stride conflict
      phase = "R12";
      do_ref(32'h0000_2200);
      do_ref(32'h0000_4200);
      do_ref(32'h0000_2200);
      do_ref(32'h0000_4200);
      idle(2);
      chk_cnt("R8");

      // R2: set index width differs by mode (bit 12 / bit 11 differences)
      phase = "R2";
      do_ref(32'h0000_0300);
      do_ref(32'h0000_1300);
      do_ref(32'h0000_0B00);
      do_ref(32'h0000_0300);
      idle(2);

      // R3: high tag bits compared
      phase = "R3";
      do_ref(32'hFFFF_FFE0);
      do_ref(32'h7FFF_FFE0);
      do_ref(32'hFFFF_FFFF);
      idle(2);

      // R11: recency order within a set
      phase = "R11";
      for (int k = 0; k < 6; k++) begin
         int unsigned seq [6] = '{0, 1, 0, 2, 0, 1};
         do_ref(32'h0000_0460 + seq[k] * 32'h2000);
      end
      idle();
      for (int k = 0; k < 8; k++) begin
         int unsigned seq [8] = '{0, 1, 2, 3, 0, 4, 1, 0};
         do_ref(32'h0000_0580 + seq[k] * 32'h2000);
      end
      idle(2);
      chk_cnt("R11");

      // R10: clear with a same-cycle reference, tags survive
      phase = "R10";
      do_ref(32'h0000_0740, 1'b1);
      idle();
      chk_cnt("R10");
      do_ref(32'h0000_0740);
      do_ref(32'h0000_1040);
      idle(2);
      chk_cnt("R10");

      // R6/R11/R9: random mix with gaps and back-to-back cycles
      phase = "R11";
      for (int k = 0; k < 3000; k++) begin
         a = ($urandom_range(0, 5) << 13) | ($urandom_range(0, 3) << 5)
             | $urandom_range(0, 31);
         if ($urandom_range(0, 7) == 0) a = a | 32'hABC0_0000;
         do_ref(a);
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 2));
      end
      idle(3);
      chk_cnt("R9");
      check(rc2 == 6'd63, "R9", "ref_count saturated w4", rc2, 63);
      check(mc2 == 6'd63, "R9", "miss_count saturated w4", mc2, 63);
      do_ref(32'h0000_0000);
      idle(2);
      check(rc2 == 6'd63, "R9", "ref_count stays saturated w4", rc2, 63);

      for (int i = 0; i < 3; i++)
         check(q_hit[i].size() == 0, "R6", $sformatf("results outstanding w%0d", m_ways[i]),
               q_hit[i].size(), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule